// File: doc/BRIEF.md
# Reset Boot Mode Sequencer

This block decides how a processor starts once its active-low reset is released. On the first clock edge after release it captures a two-bit boot-mode selection and a byte-order input. It holds these values until the next reset. A stall output keeps the CPU frozen while the chosen start-up action runs. When that action completes, the block drops the stall, gives a one-cycle run pulse and raises a permanent boot-done flag. The CPU always begins execution at address 0.

Three actions are available:
- **No boot:** the CPU is released at once.
- **Host boot:** the block waits for a host to set an interrupt bit.
- **ROM boot:** the block fetches 1024 bytes, one at a time, from an external byte-wide ROM window through a request/valid port whose latency may vary. It packs every four bytes into one 32-bit word in the captured byte order and writes the 256 words to memory word addresses 0 to 255. This is one uninterrupted block transfer.

The host interrupt bit is also used after boot. A host sets it, and the CPU clears it. A set that lands while the CPU is stalled never reaches the CPU as an interrupt.

Top module: `boot_seq`

## Requirements
- R1: While rst_ni is low: cpu_stall_o=1, boot_done_o=0, cpu_run_o=0, rom_req_o=0, mem_we_o=0, host_int_o=0, cpu_int_o=0.
- R2: Modes 2'b00 and 2'b11 are no-boot. At the first clock edge after reset release, cpu_stall_o falls, cpu_run_o pulses for one cycle and boot_done_o rises. No ROM read or memory write ever occurs.
- R3: Mode 2'b01 is host boot. cpu_stall_o stays high until host_int_o is 1, and falls one clock edge later together with the run pulse.
- R4: A host set that is accepted while cpu_stall_o is high produces no cpu_int_o pulse. One that is accepted while the CPU runs produces a one-cycle cpu_int_o pulse in the next cycle.
- R5: host_int_o is set by host_int_set_i and stays set until cpu_int_clr_i. A clear wins over a set in the same cycle. A set while the bit is already 1 is ignored and gives no cpu_int_o pulse.
- R6: In modes other than host boot, host_int_o has no effect on cpu_stall_o.
- R7: Mode 2'b10 is ROM boot. ROM byte addresses 0 to 1023 are read in ascending order. rom_req_o stays high with a stable address until rom_vld_i. Exactly one mem_we_o write is made per four bytes, to word addresses 0 to 255 in ascending order.
- R8: With latched big_endian_i=0, the first byte of each group lands in bits 7:0. With big_endian_i=1, it lands in bits 31:24.
- R9: In ROM boot, every write occurs while cpu_stall_o is high. The stall falls, with the run pulse and boot_done_o, one cycle after the last write.
- R10: boot_mode_i and big_endian_i are sampled only at the first clock edge after reset release. Later changes have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_mode_i | input | 2 | Boot selection: 00 none, 01 host, 10 ROM, 11 none |
| big_endian_i | input | 1 | Byte order for word packing (1 = first byte most significant) |
| rom_req_o | output | 1 | ROM byte read request, held until valid |
| rom_addr_o | output | 10 | ROM byte address |
| rom_vld_i | input | 1 | ROM data valid, consumed while request is high |
| rom_data_i | input | 8 | ROM read byte |
| mem_we_o | output | 1 | Memory word write strobe |
| mem_addr_o | output | 8 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| host_int_set_i | input | 1 | Host write setting the interrupt bit |
| cpu_int_clr_i | input | 1 | CPU write clearing the interrupt bit |
| host_int_o | output | 1 | Current interrupt bit |
| cpu_int_o | output | 1 | Interrupt pulse delivered to a running CPU |
| cpu_stall_o | output | 1 | CPU stall |
| cpu_run_o | output | 1 | One-cycle pulse: CPU starts at address 0 |
| boot_done_o | output | 1 | Boot finished; stays set until reset |

## Verification
Each kind of internal fault shows up at the ports within a bounded time:
- **Wrong captured mode:** visible at the first sample after release, as a stall that falls too early or stays high, or as a ROM request in a mode that should have none.
- **Byte-lane or counter error in the packer:** the scoreboard reports it on the first mismatching word, at most four bytes after the fault.
- **Early or late release:** the single-cycle gap between the last write and the falling stall exposes it.
- **Wrongly kept interrupt bit:** a missing or extra cpu_int_o pulse shows it one cycle after the host set.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    MODE_NONE     = 2'b00,
    MODE_HOST     = 2'b01,
    MODE_ROM      = 2'b10,
    MODE_NONE_ALT = 2'b11
  } boot_mode_e;

  typedef enum logic [1:0] {
    ST_LATCH,
    ST_HOST_WAIT,
    ST_ROM_WAIT,
    ST_RUN
  } seq_state_e;

endpackage

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       big_endian_i,
  input  logic       host_bit_i,
  input  logic       copy_done_i,
  output logic       copy_start_o,
  output logic       big_endian_o,
  output logic       stall_o,
  output logic       run_o,
  output logic       done_o
);

  seq_state_e state_q;
  boot_mode_e mode_q;
  logic       endian_q;
  logic       stall_q, run_q, done_q, start_q;
  logic       release_now;

  always_comb begin
    release_now = 1'b0;
    unique case (state_q)
      ST_LATCH: begin
        unique case (boot_mode_e'(mode_i))
          MODE_HOST, MODE_ROM: release_now = 1'b0;
          default:             release_now = 1'b1;
        endcase
      end
      ST_HOST_WAIT: release_now = host_bit_i;
      ST_ROM_WAIT:  release_now = copy_done_i;
      default:      release_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_LATCH;
      mode_q   <= MODE_NONE;
      endian_q <= 1'b0;
      stall_q  <= 1'b1;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
      if (release_now) begin
        state_q <= ST_RUN;
        stall_q <= 1'b0;
        run_q   <= 1'b1;
        done_q  <= 1'b1;
      end
      if (state_q == ST_LATCH) begin
        // one-time capture of strap inputs
        mode_q   <= boot_mode_e'(mode_i);
        endian_q <= big_endian_i;
        unique case (boot_mode_e'(mode_i))
          MODE_HOST: state_q <= ST_HOST_WAIT;
          MODE_ROM: begin
            state_q <= ST_ROM_WAIT;
            start_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign copy_start_o = start_q;
  assign big_endian_o = endian_q;
  assign stall_o      = stall_q;
  assign run_o        = run_q;
  assign done_o       = done_q;

  logic unused_mode;
  assign unused_mode = ^mode_q;

endmodule

// File: rtl/boot_seq_host_gate.sv
module boot_seq_host_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic stalled_i,
  output logic bit_o,
  output logic cpu_int_o
);

  logic bit_q, int_q;
  logic accept;

  // new event only from a clear bit, and a same-cycle clear cancels it
  assign accept = set_i && !bit_q && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      if (clr_i)       bit_q <= 1'b0;
      else if (set_i)  bit_q <= 1'b1;
      // not retained when the CPU is stalled
      int_q <= accept && !stalled_i;
    end
  end

  assign bit_o     = bit_q;
  assign cpu_int_o = int_q;

endmodule

// File: rtl/boot_seq_rom_copy.sv
module boot_seq_rom_copy #(
  parameter int ROM_BYTES = 1024,
  parameter int WORD_W    = 32,
  parameter int BYTE_W    = 8,
  localparam int LANES    = WORD_W / BYTE_W,
  localparam int LANE_W   = $clog2(LANES),
  localparam int ROM_AW   = $clog2(ROM_BYTES),
  localparam int MEM_AW   = ROM_AW - LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              big_endian_i,
  output logic              rom_req_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic              rom_vld_i,
  input  logic [BYTE_W-1:0] rom_data_i,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              done_o
);

  localparam logic [ROM_AW-1:0] LAST_BYTE = ROM_AW'(ROM_BYTES - 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic              active_q;
  logic [ROM_AW-1:0] cnt_q;
  logic [WORD_W-1:0] acc_q, acc_next;
  logic              we_q, done_q;
  logic [MEM_AW-1:0] waddr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [LANE_W-1:0] lane;
  logic              take;

  assign lane = cnt_q[LANE_W-1:0];
  assign take = active_q && rom_vld_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LANE_W-1:0] FWD = LANE_W'(g);
    localparam logic [LANE_W-1:0] REV = LANE_W'(LANES - 1 - g);
    logic hit;
    assign hit = (lane == (big_endian_i ? REV : FWD));
    assign acc_next[g*BYTE_W +: BYTE_W] = hit ? rom_data_i : acc_q[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
      we_q     <= 1'b0;
      done_q   <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (take) begin
        acc_q <= acc_next;
        if (lane == LAST_LANE) begin
          we_q    <= 1'b1;
          waddr_q <= cnt_q[ROM_AW-1:LANE_W];
          wdata_q <= acc_next;
        end
        if (cnt_q == LAST_BYTE) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rom_req_o   = active_q;
  assign rom_addr_o  = cnt_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = waddr_q;
  assign mem_wdata_o = wdata_q;
  assign done_o      = done_q;

endmodule

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int ROM_BYTES = 1024,
  parameter int WORD_W    = 32,
  parameter int BYTE_W    = 8,
  localparam int LANES    = WORD_W / BYTE_W,
  localparam int LANE_W   = $clog2(LANES),
  localparam int ROM_AW   = $clog2(ROM_BYTES),
  localparam int MEM_AW   = ROM_AW - LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        boot_mode_i,
  input  logic              big_endian_i,
  output logic              rom_req_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic              rom_vld_i,
  input  logic [BYTE_W-1:0] rom_data_i,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              host_int_set_i,
  input  logic              cpu_int_clr_i,
  output logic              host_int_o,
  output logic              cpu_int_o,
  output logic              cpu_stall_o,
  output logic              cpu_run_o,
  output logic              boot_done_o
);

  logic copy_start, copy_done, endian_lat, host_bit, stall;

  boot_seq_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (boot_mode_i),
    .big_endian_i (big_endian_i),
    .host_bit_i   (host_bit),
    .copy_done_i  (copy_done),
    .copy_start_o (copy_start),
    .big_endian_o (endian_lat),
    .stall_o      (stall),
    .run_o        (cpu_run_o),
    .done_o       (boot_done_o)
  );

  boot_seq_host_gate u_host (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (host_int_set_i),
    .clr_i     (cpu_int_clr_i),
    .stalled_i (stall),
    .bit_o     (host_bit),
    .cpu_int_o (cpu_int_o)
  );

  boot_seq_rom_copy #(
    .ROM_BYTES (ROM_BYTES),
    .WORD_W    (WORD_W),
    .BYTE_W    (BYTE_W)
  ) u_copy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (copy_start),
    .big_endian_i (endian_lat),
    .rom_req_o    (rom_req_o),
    .rom_addr_o   (rom_addr_o),
    .rom_vld_i    (rom_vld_i),
    .rom_data_i   (rom_data_i),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .done_o       (copy_done)
  );

  assign host_int_o  = host_bit;
  assign cpu_stall_o = stall;

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int ROM_AW = 10,
  parameter int MEM_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rom_req_o,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic              rom_vld_i,
  input logic              mem_we_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              cpu_int_clr_i,
  input logic              host_int_o,
  input logic              cpu_int_o,
  input logic              cpu_stall_o,
  input logic              cpu_run_o,
  input logic              boot_done_o
);

  assert_stall_fall_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_stall_o) |-> cpu_run_o && boot_done_o);

  assert_run_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_run_o |=> !cpu_run_o && !cpu_stall_o);

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o |=> boot_done_o);

  assert_write_in_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> cpu_stall_o);

  assert_int_only_running_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_int_o |-> !cpu_stall_o && host_int_o);

  assert_bit_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_int_o && !cpu_int_clr_i |=> host_int_o);

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_req_o && !rom_vld_i |=> rom_req_o && $stable(rom_addr_o));

  assert_req_stalled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_req_o |-> cpu_stall_o);

  logic unused_addr;
  assign unused_addr = ^mem_addr_o;

endmodule

bind boot_seq boot_seq_chk #(.ROM_AW(ROM_AW), .MEM_AW(MEM_AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rom_req_o     (rom_req_o),
  .rom_addr_o    (rom_addr_o),
  .rom_vld_i     (rom_vld_i),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .cpu_int_clr_i (cpu_int_clr_i),
  .host_int_o    (host_int_o),
  .cpu_int_o     (cpu_int_o),
  .cpu_stall_o   (cpu_stall_o),
  .cpu_run_o     (cpu_run_o),
  .boot_done_o   (boot_done_o)
);

// File: tb/boot_seq_bench.sv
module boot_seq_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  boot_mode_i = 2'b00;
  logic        big_endian_i = 1'b0;
  logic        rom_req_o;
  logic [9:0]  rom_addr_o;
  logic        rom_vld_i = 1'b0;
  logic [7:0]  rom_data_i = '0;
  logic        mem_we_o;
  logic [7:0]  mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        host_int_set_i = 1'b0;
  logic        cpu_int_clr_i = 1'b0;
  logic        host_int_o, cpu_int_o, cpu_stall_o, cpu_run_o, boot_done_o;

  always #2 clk_i = ~clk_i;

  boot_seq u_boot_seq (.*);

  int total = 0;
  int bad = 0;
  logic [39:0] exp_q[$];
  int wr_count = 0;
  int rd_next = 0;
  int rd_err = 0;
  bit finished = 0;

  function automatic logic [7:0] rom_byte(int a);
    return 8'((a * 37) + (a >> 3) + 8'h5A);
  endfunction

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: expected words for a ROM copy
  task automatic push_rom(bit big);
    for (int w = 0; w < 256; w++) begin
      logic [31:0] d;
      for (int b = 0; b < 4; b++) begin
        int pos = big ? 3 - b : b;
        d[pos*8 +: 8] = rom_byte(4*w + b);
      end
      exp_q.push_back({8'(w), d});
    end
  endtask

  // monitor: compare every write against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && mem_we_o) begin
      wr_count++;
      if (exp_q.size() == 0) chk("R7 extra write", {mem_addr_o, mem_wdata_o}, 40'h0);
      else chk("R7/R8 write", {mem_addr_o, mem_wdata_o}, exp_q.pop_front());
    end
  end

  // ROM responder with varying latency
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk_i);
      rom_vld_i = 1'b0;
      if (rst_ni && rom_req_o) begin
        repeat (lat) @(negedge clk_i);
        if (int'(rom_addr_o) != rd_next) rd_err++;
        rom_data_i = rom_byte(int'(rom_addr_o));
        rom_vld_i = 1'b1;
        rd_next++;
        lat = (int'(rom_addr_o) * 5) % 4;
      end
    end
  end

  task automatic do_reset(logic [1:0] mode, bit big);
    rst_ni = 1'b0;
    boot_mode_i = mode;
    big_endian_i = big;
    wr_count = 0;
    rd_next = 0;
    rd_err = 0;
    exp_q.delete();
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs",
        {33'b0, cpu_stall_o, boot_done_o, cpu_run_o, rom_req_o, mem_we_o, host_int_o, cpu_int_o},
        {33'b0, 7'b1000000});
    rst_ni = 1'b1;
  endtask

  task automatic pulse(bit set, bit clr);
    host_int_set_i = set;
    cpu_int_clr_i = clr;
    @(negedge clk_i);
    host_int_set_i = 1'b0;
    cpu_int_clr_i = 1'b0;
  endtask

  task automatic no_boot(logic [1:0] mode);
    do_reset(mode, 1'b0);
    @(negedge clk_i);
    chk("R2 release at first edge", {37'b0, cpu_stall_o, cpu_run_o, boot_done_o}, {37'b0, 3'b011});
    @(negedge clk_i);
    chk("R2 run single pulse", {38'b0, cpu_run_o, boot_done_o}, {38'b0, 2'b01});
    repeat (5) @(negedge clk_i);
    chk("R2 no rom or write", {38'b0, rom_req_o, 1'(wr_count != 0)}, 40'h0);
  endtask

  task automatic rom_boot(bit big);
    bit stall_bad = 0;
    do_reset(2'b10, big);
    push_rom(big);
    @(negedge clk_i);
    // R10: strap changes after capture are ignored
    boot_mode_i = 2'b00;
    big_endian_i = ~big;
    repeat (40) @(negedge clk_i);
    pulse(1'b1, 1'b0);
    repeat (3) @(negedge clk_i);
    chk("R6 host bit no release in ROM mode", {37'b0, host_int_o, cpu_stall_o, cpu_int_o}, {37'b0, 3'b110});
    while (wr_count < 256) begin
      @(negedge clk_i); #1;
      if (!cpu_stall_o) stall_bad = 1;
    end
    chk("R9 stalled through last write", {39'b0, stall_bad}, 40'h0);
    @(negedge clk_i);
    chk("R9 release after last write", {36'b0, cpu_stall_o, cpu_run_o, boot_done_o, cpu_int_o}, {36'b0, 4'b0110});
    chk("R7 byte read order", 40'(rd_err), 40'h0);
    chk("R7 byte read count", 40'(rd_next), 40'd1024);
    repeat (10) @(negedge clk_i);
    chk("R7 write count", 40'(wr_count), 40'd256);
    chk("R5 bit held after boot", {39'b0, host_int_o}, 40'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    // no-boot encodings
    no_boot(2'b00);
    no_boot(2'b11);

    // host boot
    do_reset(2'b01, 1'b0);
    @(negedge clk_i);
    boot_mode_i = 2'b00;  // R10
    begin
      bit early = 0;
      repeat (20) begin
        @(negedge clk_i);
        if (!cpu_stall_o || cpu_run_o || rom_req_o) early = 1;
      end
      chk("R3 stall held before host bit", {39'b0, early}, 40'h0);
    end
    pulse(1'b1, 1'b0);
    chk("R3 bit set, still stalled", {37'b0, host_int_o, cpu_stall_o, cpu_int_o}, {37'b0, 3'b110});
    @(negedge clk_i);
    chk("R4 release without cpu interrupt", {37'b0, cpu_stall_o, cpu_run_o, cpu_int_o}, {37'b0, 3'b010});
    pulse(1'b1, 1'b0);
    chk("R5 set while set ignored", {38'b0, host_int_o, cpu_int_o}, {38'b0, 2'b10});
    pulse(1'b0, 1'b1);
    chk("R5 cpu clears bit", {39'b0, host_int_o}, 40'h0);
    pulse(1'b1, 1'b1);
    chk("R5 clear wins", {38'b0, host_int_o, cpu_int_o}, 40'h0);
    pulse(1'b1, 1'b0);
    chk("R4 interrupt while running", {38'b0, host_int_o, cpu_int_o}, {38'b0, 2'b11});
    @(negedge clk_i);
    chk("R4 interrupt one cycle", {39'b0, cpu_int_o}, 40'h0);

    // ROM boot both byte orders
    rom_boot(1'b0);
    rom_boot(1'b1);

    finish_run();
  end

endmodule